// File: doc/BRIEF.md
# Write-Completion Status Read Responder

This block sits on the read path of a byte-wide non-volatile memory model. When no internal programming cycle is running, it returns the data that the storage array presents. While programming is running, it returns a status byte in place of array data. The host can then tell that the write is still in progress in two ways at once. The top bit holds the complement of the top bit of the byte most recently written. The bit below it flips from one read to the next.

A host may begin polling at any point in the programming period. This includes the period that follows a write attempt rejected by the protection logic, because that attempt also holds the busy flag for the full programming time. Each completed read strobe captures one response into the output register. That value is visible on the following cycle and stays put until the next strobe. The toggle state moves only on reads. It starts again from zero in every programming period.

Top module: `wr_status_resp`

## Requirements
- R1: While reset is asserted (rst_n low) and after it is released, `rdData` reads 0x00 until the first read strobe is captured.
- R2: A read strobed while `busy` is high returns, on bit 7 of `rdData`, the inverse of bit 7 of `lastData`.
- R3: A read strobed while `busy` is high returns bits 5..0 of `lastData` unchanged on bits 5..0 of `rdData`. `arrayData` has no effect on the result.
- R4: Bit 6 of a read strobed while `busy` is high is 0 on the first such read of a programming period. It takes the opposite value on each later read in the same period. Cycles without a read strobe do not advance it.
- R5: A read strobed while `busy` is low returns all 8 bits of `arrayData`. This includes a read in the very cycle in which `busy` falls.
- R6: The response to a strobe taken at clock edge N appears on `rdData` after edge N. It holds unchanged through later cycles without a strobe, whatever the other inputs do.
- R7: When a programming period ends and a new one begins, bit 6 of the first read in the new period is 0, whatever value the previous period ended on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | One-cycle pulse marking a completed host read |
| busy | input | 1 | High while an internal programming cycle is running |
| lastData | input | 8 | Byte most recently written by the host |
| arrayData | input | 8 | True stored data for the addressed location |
| rdData | output | 8 | Data returned to the host, registered |

## Verification
The assertions assume that `busy`, `lastData`, `arrayData` and `rdStrobe` are driven to known values from time zero, and that each of them changes only between clock edges. They also assume that a read strobe lasts exactly one cycle, so that every strobe stands for one host read. The stimulus applies every input change at the falling edge and lowers `rdStrobe` one cycle after raising it. It raises and lowers `busy` only at those falling edges, including the cycle where `busy` falls together with a strobe.

// File: rtl/rdstat_pkg.sv
package rdstat_pkg;

  // Per-cycle strobes that the control half hands to the datapath half.
  typedef struct packed {
    logic capture;    // load the output register this cycle
    logic statusSel;  // choose the status word over array data
    logic toggleAdv;  // flip the toggle state
    logic toggleClr;  // hold the toggle state at zero
  } rdCtrl_t;

endpackage

// File: rtl/rdstat_ctrl.sv
module rdstat_ctrl
  import rdstat_pkg::*;
(
  input  logic    rdStrobe,
  input  logic    busy,
  output rdCtrl_t ctrl
);

  // Busy is looked at in the same cycle as the strobe, so a read that lands
  // in the cycle busy drops already takes the true-data path.
  always_comb begin
    ctrl.capture   = rdStrobe;
    ctrl.statusSel = rdStrobe & busy;
    ctrl.toggleAdv = rdStrobe & busy;
    ctrl.toggleClr = ~busy;
  end

endmodule

// File: rtl/rdstat_dpath.sv
module rdstat_dpath
  import rdstat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rdCtrl_t           ctrl,
  input  logic [DATA_W-1:0] lastData,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData
);

  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic              toggleQ;
  logic [DATA_W-1:0] statusWord;

  // Build the status word one bit at a time.
  for (genvar i = 0; i < DATA_W; i++) begin : gStat
    if (i == POLL_BIT) begin : gPoll
      assign statusWord[i] = ~lastData[i];
    end else if (i == TOG_BIT) begin : gTog
      assign statusWord[i] = toggleQ;
    end else begin : gPass
      assign statusWord[i] = lastData[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      toggleQ <= 1'b0;
      rdData  <= '0;
    end else begin
      if (ctrl.toggleClr)      toggleQ <= 1'b0;
      else if (ctrl.toggleAdv) toggleQ <= ~toggleQ;
      if (ctrl.capture)
        rdData <= ctrl.statusSel ? statusWord : arrayData;
    end
  end

  // Outside a programming period the toggle state must rest at zero.
  AST_TOGGLE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.toggleClr |=> (toggleQ == 1'b0)); // R7

  // A status capture must advance the toggle state.
  AST_TOGGLE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.statusSel && !ctrl.toggleClr) |=> (toggleQ != $past(toggleQ))); // R4

endmodule

// File: rtl/wr_status_resp.sv
module wr_status_resp
  import rdstat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rdStrobe,
  input  logic       busy,
  input  logic [7:0] lastData,
  input  logic [7:0] arrayData,
  output logic [7:0] rdData
);

  localparam int DATA_W = 8;

  rdCtrl_t ctrl;

  rdstat_ctrl u_ctrl (
    .rdStrobe (rdStrobe),
    .busy     (busy),
    .ctrl     (ctrl)
  );

  rdstat_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .lastData  (lastData),
    .arrayData (arrayData),
    .rdData    (rdData)
  );

  AST_POLL_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStrobe && busy) |=> (rdData[7] == ~$past(lastData[7]))); // R2

  AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStrobe && busy) |=> (rdData[5:0] == $past(lastData[5:0]))); // R3

  AST_TRUE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStrobe && !busy) |=> (rdData == $past(arrayData))); // R5

  AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rdStrobe |=> $stable(rdData)); // R6

  AST_TOGGLE_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStrobe && busy && !$past(busy)) |=> (rdData[6] == 1'b0)); // R7

endmodule

// File: tb/sim_wr_status_resp.sv
`timescale 1ns/1ps
module sim_wr_status_resp;

  localparam time CLK_HALF = 4ns;  // 125 MHz

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rdStrobe = 1'b0;
  logic       busy = 1'b0;
  logic [7:0] lastData = 8'h00;
  logic [7:0] arrayData = 8'h00;
  logic [7:0] rdData;

  int checks = 0;
  int failures = 0;
  logic tbToggle = 1'b0;
  expItem_t sbQ[$];
  bit done = 1'b0;

  always #(CLK_HALF) clk = ~clk;

  wr_status_resp u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .rdStrobe  (rdStrobe),
    .busy      (busy),
    .lastData  (lastData),
    .arrayData (arrayData),
    .rdData    (rdData)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Driver: computes the expected response from the requirements and queues it.
  task automatic doRead();
    expItem_t it;
    @(negedge clk);
    if (busy) begin
      it.exp = {~lastData[7], tbToggle, lastData[5:0]};
      it.tag = (tbToggle == 1'b0) ? "R2,R3,R4,R7" : "R2,R3,R4";
      tbToggle = ~tbToggle;
    end else begin
      it.exp = arrayData;
      it.tag = "R5";
    end
    sbQ.push_back(it);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic setBusy(input logic v);
    @(negedge clk);
    busy = v;
    if (!v) tbToggle = 1'b0;
  endtask

  // R5: read in the very cycle busy falls must return true data.
  task automatic readOnBusyFall();
    expItem_t it;
    @(negedge clk);
    busy = 1'b0;
    tbToggle = 1'b0;
    it.exp = arrayData;
    it.tag = "R5";
    sbQ.push_back(it);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: after each captured strobe, compare the registered output.
  initial begin
    forever begin
      @(posedge clk);
      if (rdStrobe && rst_n) begin
        @(negedge clk);
        if (sbQ.size() == 0) begin
          check(1'b0, "R6", rdData, 8'hxx);
        end else begin
          expItem_t it;
          it = sbQ.pop_front();
          check(rdData === it.exp, it.tag, rdData, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_HALF * 2 * 200000);
    check(1'b0, "R6", rdData, 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] held;
    idle(3);
    check(rdData === 8'h00, "R1", rdData, 8'h00);      // R1 during reset
    rst_n = 1'b1;
    idle(2);
    check(rdData === 8'h00, "R1", rdData, 8'h00);      // R1 after release

    // R5: plain reads with no programming
    arrayData = 8'hA5; doRead();
    arrayData = 8'h5A; doRead();

    // R2, R3, R4: first programming period, bit 7 of last byte = 0
    lastData = 8'h3C; arrayData = 8'hFF;
    setBusy(1'b1);
    doRead();
    idle(4);                   // idle cycles must not advance the toggle (R4)
    arrayData = 8'h00; doRead();
    doRead();
    idle(1);
    doRead();

    // R6: output holds while no strobe arrives, other inputs moving
    held = rdData;
    arrayData = 8'h77; lastData = 8'h81;
    idle(3);
    check(rdData === held, "R6", rdData, held);

    // Bit 7 of last byte = 1; three more reads leave the toggle at 1
    lastData = 8'hC3;
    doRead();
    doRead();
    doRead();

    // R5: busy falls in the read cycle; true data expected
    arrayData = 8'h96;
    readOnBusyFall();

    // R7: new period after an odd count, first toggle is 0
    lastData = 8'h40; arrayData = 8'h12;
    setBusy(1'b1);
    idle(6);
    doRead();
    doRead();
    setBusy(1'b0);
    doRead();                  // R5 after completion

    // Rejected-write style period: polling starts late in the period
    lastData = 8'hE0;
    setBusy(1'b1);
    idle(20);
    doRead();
    doRead();
    setBusy(1'b0);
    arrayData = 8'h3E;
    doRead();

    idle(3);
    check(sbQ.size() == 0, "R6", 8'(sbQ.size()), 8'h00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule